// File: doc/BRIEF.md
# Sample Offset and Format Stage

This stage sits between a converter core and its serial output path. Each valid input sample is an unsigned offset-binary code. The stage adds a signed trim value to it and clamps the sum to the legal code range. It then re-encodes the result either as offset binary or as two's complement. As a last step it can complement every output bit. A single output register holds the result, and a valid flag is delayed to match that register.

The trim, format and invert controls come from a configuration register owned outside the block. That register resets the trim to zero and the format to two's complement. The stage applies whatever values those controls have in the cycle a sample is accepted.

Top module: `sample_trim_fmt`

## Requirements
- R1: While rst_ni is low, out_valid_o and out_sample_o are both zero.
- R2: out_valid_o is high in the cycle after in_valid_i is high, and low in the cycle after in_valid_i is low (one register of latency).
- R3: With twos_fmt_i = 0 and invert_i = 0, out_sample_o equals in_sample_i plus the sign-extended 8-bit two's complement trim_i, as an unsigned 14-bit code.
- R4: A sum above 0x3FFF is clamped to 0x3FFF. It does not wrap.
- R5: A sum below 0 is clamped to 0x0000. It does not wrap.
- R6: twos_fmt_i = 1 gives the two's complement code, which is the clamped offset-binary value with bit 13 inverted. Midscale 0x2000 becomes 0x0000.
- R7: invert_i = 1 complements all 14 output bits. This happens after the format step.
- R8: A cycle with in_valid_i low leaves out_sample_o unchanged, whatever the other inputs are.
- R9: The trim covers the whole range -128 (0x80) to +127 (0x7F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample qualifier |
| in_sample_i | input | 14 | Offset-binary input sample |
| trim_i | input | 8 | Signed offset trim in LSBs |
| twos_fmt_i | input | 1 | 0 = offset binary, 1 = two's complement |
| invert_i | input | 1 | Complement all output bits |
| out_valid_o | output | 1 | Output qualifier |
| out_sample_o | output | 14 | Formatted output sample |

## Verification
Every result of the stage is due exactly one rising edge after the edge that accepts the input. This covers the valid flag, the trimmed and clamped value, the format step, the inversion, and holding the value when no sample arrives. Inputs change on the falling edge. Each check waits for the next rising edge and then reads the outputs 1 ns later, which keeps them clear of the edge. The reset state is read while reset is still held, before any edge has a chance to load the register.

// File: rtl/stf_pkg.sv
package stf_pkg;
  localparam int unsigned DATA_W = 14;
  localparam int unsigned TRIM_W = 8;

  typedef struct packed {
    logic             vld;
    logic [DATA_W-1:0] data;
  } smp_t;
endpackage

// File: rtl/stf_trim_sat.sv
module stf_trim_sat #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned TRIM_W = 8
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic [DATA_W-1:0] sum_o
);
  // two spare bits: one for carry, one for sign
  localparam int unsigned SUM_W = DATA_W + 2;

  logic [SUM_W-1:0] ext_trim;
  logic [SUM_W-1:0] sum;

  assign ext_trim = {{(SUM_W-TRIM_W){trim_i[TRIM_W-1]}}, trim_i};
  assign sum      = {2'b00, sample_i} + ext_trim;

  always_comb begin
    if (sum[SUM_W-1])      sum_o = '0;
    else if (sum[SUM_W-2]) sum_o = '1;
    else                   sum_o = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/stf_code_fmt.sv
module stf_code_fmt #(
  parameter int unsigned DATA_W = 14
) (
  input  logic [DATA_W-1:0] ob_i,
  input  logic              twos_i,
  input  logic              inv_i,
  output logic [DATA_W-1:0] code_o
);
  logic [DATA_W-1:0] fmt;

  always_comb begin
    fmt = ob_i;
    if (twos_i) fmt[DATA_W-1] = ~ob_i[DATA_W-1];
  end

  assign code_o = inv_i ? ~fmt : fmt;
endmodule

// File: rtl/sample_trim_fmt.sv
module sample_trim_fmt
  import stf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_sample_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              twos_fmt_i,
  input  logic              invert_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_sample_o
);
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] coded;
  smp_t              q;

  stf_trim_sat #(.DATA_W(DATA_W), .TRIM_W(TRIM_W)) u_sat (
    .sample_i (in_sample_i),
    .trim_i   (trim_i),
    .sum_o    (clamped)
  );

  stf_code_fmt #(.DATA_W(DATA_W)) u_fmt (
    .ob_i   (clamped),
    .twos_i (twos_fmt_i),
    .inv_i  (invert_i),
    .code_o (coded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      q.vld <= in_valid_i;
      if (in_valid_i) q.data <= coded;
    end
  end

  assign out_valid_o  = q.vld;
  assign out_sample_o = q.data;
endmodule

// File: rtl/sample_trim_fmt_chk.sv
module sample_trim_fmt_chk
  import stf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_sample_i,
  input logic [TRIM_W-1:0] trim_i,
  input logic              twos_fmt_i,
  input logic              invert_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_sample_o
);
  localparam logic [DATA_W-1:0] MAXC = '1;
  localparam logic [DATA_W-1:0] MSB  = 1 << (DATA_W-1);

  logic plain;
  assign plain = (trim_i == '0);

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && out_sample_o == '0));

  a_r2_valid_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r2_valid_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r3_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && plain && !twos_fmt_i && !invert_i)
      |=> out_sample_o == $past(in_sample_i));

  a_r4_clamp_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sample_i == MAXC && !trim_i[TRIM_W-1] && !twos_fmt_i && !invert_i)
      |=> out_sample_o == MAXC);

  a_r5_clamp_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sample_i == '0 && trim_i[TRIM_W-1] && !twos_fmt_i && !invert_i)
      |=> out_sample_o == '0);

  a_r6_twos_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && plain && twos_fmt_i && !invert_i)
      |=> out_sample_o == ($past(in_sample_i) ^ MSB));

  a_r7_invert_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && plain && !twos_fmt_i && invert_i)
      |=> out_sample_o == ~$past(in_sample_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_sample_o));
endmodule

bind sample_trim_fmt sample_trim_fmt_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_sample_i  (in_sample_i),
  .trim_i       (trim_i),
  .twos_fmt_i   (twos_fmt_i),
  .invert_i     (invert_i),
  .out_valid_o  (out_valid_o),
  .out_sample_o (out_sample_o)
);

// File: tb/sim_sample_trim_fmt.sv
`timescale 1ns/1ps
module sim_sample_trim_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [13:0] smp = '0;
  logic [7:0]  trim = '0;
  logic        twos = 1'b0;
  logic        inv = 1'b0;
  logic        o_vld;
  logic [13:0] o_smp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sample_trim_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .in_sample_i(smp),
    .trim_i(trim), .twos_fmt_i(twos), .invert_i(inv),
    .out_valid_o(o_vld), .out_sample_o(o_smp)
  );

  function automatic logic [13:0] model(logic [13:0] s, logic [7:0] t, logic f, logic n);
    int v;
    logic [13:0] r;
    v = int'(s) + int'($signed(t));
    if (v < 0) v = 0;
    if (v > 16383) v = 16383;
    r = 14'(v);
    if (f) r[13] = ~r[13];
    if (n) r = ~r;
    return r;
  endfunction

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one sample, check its result one edge later
  task automatic run(string req, logic [13:0] s, logic [7:0] t, logic f, logic n);
    @(negedge clk);
    vld = 1'b1; smp = s; trim = t; twos = f; inv = n;
    @(posedge clk); #1;
    chk(req, o_smp, model(s, t, f, n));
    chk("R2", {13'd0, o_vld}, 14'd1);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic t_reset;
    #2;
    chk("R1", o_smp, 14'h0000);
    chk("R1", {13'd0, o_vld}, 14'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_trim;
    run("R3", 14'h1000, 8'h05, 1'b0, 1'b0);
    run("R3", 14'h1000, 8'hFB, 1'b0, 1'b0);
    run("R3", 14'h2345, 8'h00, 1'b0, 1'b0);
    run("R9", 14'h2000, 8'h7F, 1'b0, 1'b0);
    chk("R9", o_smp, 14'h207F);
    run("R9", 14'h2000, 8'h80, 1'b0, 1'b0);
    chk("R9", o_smp, 14'h1F80);
  endtask

  task automatic t_sat;
    run("R4", 14'h3FF0, 8'h7F, 1'b0, 1'b0);
    chk("R4", o_smp, 14'h3FFF);
    run("R4", 14'h3F81, 8'h7E, 1'b0, 1'b0);
    chk("R4", o_smp, 14'h3FFF);
    run("R5", 14'h0010, 8'h80, 1'b0, 1'b0);
    chk("R5", o_smp, 14'h0000);
    run("R5", 14'h0000, 8'hFF, 1'b0, 1'b0);
    chk("R5", o_smp, 14'h0000);
  endtask

  task automatic t_fmt;
    run("R6", 14'h2000, 8'h00, 1'b1, 1'b0);
    chk("R6", o_smp, 14'h0000);
    run("R6", 14'h0000, 8'h00, 1'b1, 1'b0);
    chk("R6", o_smp, 14'h2000);
    run("R6", 14'h3FF0, 8'h7F, 1'b1, 1'b0);
    chk("R6", o_smp, 14'h1FFF);
  endtask

  task automatic t_inv;
    run("R7", 14'h0123, 8'h00, 1'b0, 1'b1);
    chk("R7", o_smp, 14'h3EDC);
    run("R7", 14'h2000, 8'h00, 1'b1, 1'b1);
    chk("R7", o_smp, 14'h3FFF);
    run("R7", 14'h0005, 8'h80, 1'b1, 1'b1);
    chk("R7", o_smp, 14'h1FFF);
  endtask

  task automatic t_hold;
    logic [13:0] held;
    run("R8", 14'h0AAA, 8'h00, 1'b0, 1'b0);
    held = o_smp;
    @(negedge clk);
    vld = 1'b0; smp = 14'h1555; trim = 8'h10; twos = 1'b1; inv = 1'b1;
    @(posedge clk); #1;
    chk("R8", o_smp, held);
    chk("R2", {13'd0, o_vld}, 14'd0);
    @(posedge clk); #1;
    chk("R8", o_smp, held);
  endtask

  initial begin
    t_reset();
    t_trim();
    t_sat();
    t_fmt();
    t_inv();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule